// File: doc/BRIEF.md
# Rotating Delay-Line State Controller

This block steps an eight-cell delay line through its rotation so that, over one full cycle, every physical delay cell serves once at every position of the chain. It keeps a 3-bit rotation state.

From that state it decodes two things:
- a one-hot select that tells each cell whether to take its input from the local oscillator or from the cell before it;
- a routing map that tells the switching matrix which baseband capacitor each cell's tap pulse must charge. Because of this map, a capacitor always collects the same absolute sample phase while the physical cells rotate underneath.

The baseband side raises a one-cycle measurement-done strobe once the capture for the current state is complete. The controller then moves to the next state, unless hold is asserted. A synchronous init returns the sequence to state 0. A single-cycle end-of-cycle flag marks the moment the sequence has visited all eight states and wrapped back to the start, which is when the baseband processor may average its eight captures. All pins are plain control and status levels; the block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `rotdl_state_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, `state` is 0, `cycle_end` is 0, `lo_sel` is 8'b0000_0001 and routing field c holds capacitor index c.
- R2: When `init` is high at a rising clock edge, `state` is 0 after that edge, whatever `hold` and `meas_done` are.
- R3: When `init` and `hold` are low and `meas_done` is high at an edge, `state` becomes (state+1) mod 8. Without `meas_done`, `state` keeps its value.
- R4: When `hold` is high and `init` is low, `state` keeps its value even if `meas_done` is high.
- R5: `lo_sel` is always one-hot. Bit c is set exactly when `state` equals c (cell c takes the oscillator input; every other cell takes the previous cell's output).
- R6: Routing field c (`route_map` bits 3c+2..3c) gives the capacitor charged by cell c's tap. Its value is (c − state) mod 8, so cell (state+j) mod 8 feeds capacitor j, and the eight fields always form a permutation of 0..7.
- R7: `cycle_end` is high for exactly one cycle: the cycle after a step from state 7 to 0. It is never set by `init`.
- R8: Over the eight states of one full cycle, every cell occupies every chain position exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous return to state 0, highest priority |
| hold | input | 1 | Freeze the rotation state |
| meas_done | input | 1 | One-cycle strobe: capture for the current state finished |
| state | output | 3 | Current rotation state |
| lo_sel | output | 8 | One-hot; bit c set means cell c is driven from the oscillator |
| route_map | output | 24 | Field c (bits 3c+2..3c) is the capacitor index for cell c's tap |
| cycle_end | output | 1 | One-cycle pulse after wrapping from state 7 to 0 |

## Verification
The sequence is driven through a full cycle of isolated strobes and then a run of back-to-back strobes. Comparing the two shows whether a step depends on strobe spacing. In every state, the select and every routing field are compared with their closed forms. The bench also builds the cell-by-position occupancy matrix; a wrong rotation direction or a skipped state shows up there as a doubled entry.

Hold is asserted together with strobes to tell freezing apart from merely idling without a strobe. Init is issued from state 7 together with a strobe and with hold, which separates init priority from a wrap that would raise the end-of-cycle flag.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_INIT = 2'd1,
    SEQ_HOLD = 2'd2,
    SEQ_STEP = 2'd3
  } seq_cmd_t;
endpackage

// File: rtl/rot_state_seq.sv
module rot_state_seq
  import rot_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 8,
  localparam int unsigned STATE_W = $clog2(NUM_CELLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               hold,
  input  logic               meas_done,
  output logic [STATE_W-1:0] state,
  output logic               cycle_end
);
  localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_CELLS - 1);

  seq_cmd_t           cmd;
  logic [STATE_W-1:0] state_q, state_d;
  logic               end_q, end_d;

  always_comb begin
    if (init)           cmd = SEQ_INIT;
    else if (hold)      cmd = SEQ_HOLD;
    else if (meas_done) cmd = SEQ_STEP;
    else                cmd = SEQ_IDLE;
  end

  always_comb begin
    state_d = state_q;
    end_d   = 1'b0;
    unique case (cmd)
      SEQ_INIT: state_d = '0;
      SEQ_STEP: begin
        if (state_q == LAST) begin
          state_d = '0;
          end_d   = 1'b1;
        end else begin
          state_d = state_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      end_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      end_q   <= end_d;
    end
  end

  assign state     = state_q;
  assign cycle_end = end_q;

  AST_INIT_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (state_q == '0)); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !hold && meas_done && state_q != LAST) |=> (state_q == $past(state_q) + 1'b1)); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !meas_done) |=> $stable(state_q)); // R3
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && hold) |=> $stable(state_q)); // R4
  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> (state_q == '0 && $past(state_q) == LAST && !$past(init))); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q); // R7
endmodule

// File: rtl/rot_lo_decoder.sv
module rot_lo_decoder #(
  parameter int unsigned NUM_CELLS = 8,
  localparam int unsigned STATE_W = $clog2(NUM_CELLS)
) (
  input  logic [STATE_W-1:0]   state,
  output logic [NUM_CELLS-1:0] lo_sel
);
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    assign lo_sel[c] = (state == STATE_W'(c));
  end
endmodule

// File: rtl/rot_route_decoder.sv
module rot_route_decoder #(
  parameter int unsigned NUM_CELLS = 8,
  localparam int unsigned STATE_W = $clog2(NUM_CELLS)
) (
  input  logic [STATE_W-1:0]           state,
  output logic [NUM_CELLS*STATE_W-1:0] route_map
);
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic [STATE_W:0] wide;
    always_comb begin
      if (STATE_W'(c) >= state) wide = (STATE_W+1)'(c) - {1'b0, state};
      else                      wide = (STATE_W+1)'(c + NUM_CELLS) - {1'b0, state};
    end
    assign route_map[c*STATE_W +: STATE_W] = wide[STATE_W-1:0];
  end
endmodule

// File: rtl/rotdl_state_ctrl.sv
module rotdl_state_ctrl #(
  parameter int unsigned NUM_CELLS = 8,
  localparam int unsigned STATE_W = $clog2(NUM_CELLS),
  localparam int unsigned MAP_W   = NUM_CELLS * STATE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 hold,
  input  logic                 meas_done,
  output logic [STATE_W-1:0]   state,
  output logic [NUM_CELLS-1:0] lo_sel,
  output logic [MAP_W-1:0]     route_map,
  output logic                 cycle_end
);
  rot_state_seq #(.NUM_CELLS(NUM_CELLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .init(init), .hold(hold),
    .meas_done(meas_done), .state(state), .cycle_end(cycle_end)
  );

  rot_lo_decoder #(.NUM_CELLS(NUM_CELLS)) u_lo (
    .state(state), .lo_sel(lo_sel)
  );

  rot_route_decoder #(.NUM_CELLS(NUM_CELLS)) u_route (
    .state(state), .route_map(route_map)
  );

  // Which capacitors are claimed by some cell in the current state.
  logic [NUM_CELLS-1:0] cap_hit;
  always_comb begin
    cap_hit = '0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      cap_hit[route_map[c*STATE_W +: STATE_W]] = 1'b1;
    end
  end

  AST_LO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lo_sel) && lo_sel[state]); // R5
  AST_HEAD_ON_CAP0: assert property (@(posedge clk) disable iff (!rst_n)
    route_map[state*STATE_W +: STATE_W] == '0); // R6
  AST_ROUTE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cap_hit) == NUM_CELLS); // R6
endmodule

// File: tb/tb_rotdl_state_ctrl.sv
`timescale 1ns/1ps
module tb_rotdl_state_ctrl;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init = 1'b0, hold = 1'b0, meas_done = 1'b0;
  logic [W-1:0] state;
  logic [N-1:0] lo_sel;
  logic [N*W-1:0] route_map;
  logic         cycle_end;

  int tests = 0, fails = 0;
  int exp_state = 0;

  always #2 clk = ~clk;

  rotdl_state_ctrl dut (
    .clk(clk), .rst_n(rst_n), .init(init), .hold(hold),
    .meas_done(meas_done), .state(state), .lo_sel(lo_sel),
    .route_map(route_map), .cycle_end(cycle_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Compare state, select and routing with the closed forms.
  task automatic check_decode(input int k);
    check(int'(state) == k, "R3 state", int'(state), k);
    check(lo_sel == N'(1 << k), "R5 lo_sel", int'(lo_sel), 1 << k);
    for (int c = 0; c < N; c++) begin
      int f = int'(route_map[c*W +: W]);
      int e = (c - k + N) % N;
      check(f == e, "R6 route field", f, e);
    end
  endtask

  // Drive one cycle of inputs at the falling edge; outputs are valid at the next falling edge.
  task automatic cyc(input bit i, input bit h, input bit m);
    @(negedge clk);
    init = i; hold = h; meas_done = m;
    @(negedge clk);
    init = 0; hold = 0; meas_done = 0;
  endtask

  task automatic t_reset();
    check(int'(state) == 0, "R1 state", int'(state), 0);
    check(cycle_end == 1'b0, "R1 cycle_end", int'(cycle_end), 0);
    check(lo_sel == 8'h01, "R1 lo_sel", int'(lo_sel), 1);
    for (int c = 0; c < N; c++)
      check(int'(route_map[c*W +: W]) == c, "R1 route", int'(route_map[c*W +: W]), c);
  endtask

  task automatic t_full_cycle();
    bit [N*N-1:0] seen = '0;
    for (int s = 0; s < N; s++) begin
      check_decode(exp_state);
      for (int c = 0; c < N; c++) seen[c*N + int'(route_map[c*W +: W])] = 1'b1;
      cyc(0, 0, 1);
      exp_state = (exp_state + 1) % N;
      check(cycle_end == (exp_state == 0), "R7 cycle_end", int'(cycle_end), int'(exp_state == 0));
    end
    check(int'(state) == 0, "R7 wrap to 0", int'(state), 0);
    check($countones(seen) == N*N, "R8 occupancy", $countones(seen), N*N);
    cyc(0, 0, 0);
    check(cycle_end == 1'b0, "R7 single pulse", int'(cycle_end), 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    meas_done = 1;
    for (int s = 0; s < 3; s++) @(negedge clk);
    meas_done = 0;
    exp_state = (exp_state + 3) % N;
    check_decode(exp_state);
  endtask

  task automatic t_no_strobe();
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    check(int'(state) == exp_state, "R3 idle keeps state", int'(state), exp_state);
  endtask

  task automatic t_hold();
    cyc(0, 1, 1);
    cyc(0, 1, 1);
    check(int'(state) == exp_state, "R4 hold freezes", int'(state), exp_state);
    check_decode(exp_state);
  endtask

  task automatic t_init_priority();
    while (exp_state != N - 1) begin
      cyc(0, 0, 1);
      exp_state = (exp_state + 1) % N;
    end
    check(int'(state) == 7, "R3 reached 7", int'(state), 7);
    cyc(1, 1, 1);
    exp_state = 0;
    check(int'(state) == 0, "R2 init wins", int'(state), 0);
    check(cycle_end == 1'b0, "R7 no pulse on init", int'(cycle_end), 0);
    cyc(1, 0, 0);
    check(int'(state) == 0, "R2 init at 0", int'(state), 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_cycle();
    t_back_to_back();
    t_no_strobe();
    t_hold();
    t_init_priority();
    t_full_cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule